// File: doc/BRIEF.md
# Multi-Polynomial CRC Insert/Check Engine

This block computes a cyclic redundancy check over a stream of byte beats, using one of eight generator polynomials whose widths run from 6 to 32 bits. A block begins with a one-cycle start strobe. The strobe latches the polynomial code and the direction, and it clears the remainder register. Payload beats then flow in over a valid/ready handshake. The last beat carries an end marker and may hold only part of a byte.

In insert direction the payload is forwarded one cycle later. The finished CRC follows it as extra beats. In check direction the payload is forwarded with nothing appended. The remainder is compared with a CRC value that arrives on a side port with the last beat, and a pass or fail result is reported. In both directions a `done` pulse closes the block, and the next block may start in that same cycle.

Top module: `crc_engine`

## Requirements
- R1: `poly_sel` selects the generator, given as width and the low coefficients in hex: 0 = 24/0x800063, 1 = 24/0x864CFB, 2 = 16/0x1021, 3 = 16/0x8005, 4 = 32/0x04C11DB7, 5 = 18/0x26DCD, 6 = 12/0xD31, 7 = 6/0x2F. The code is latched by `blk_start`.
- R2: The remainder starts at zero for each block. Bits enter MSB first. The result is neither reflected nor XORed, so code 2 over the ASCII digits "123456789" gives 0x31C3.
- R3: With `chk_mode`=0, every accepted payload beat appears on the output one cycle later, unchanged and with the same bit count. The CRC beats follow back to back. There are ceil(w/8) of them, MSB first and left-aligned. The final CRC beat has `out_nbits` = w - 8*(ceil(w/8)-1) and carries `out_last`.
- R4: On a beat with `in_last`=1, only the top `in_nbits` bits of `in_data` (1 to 8) enter the CRC. The lower bits do not change the result.
- R5: With `chk_mode`=1, only the payload is forwarded, and `out_last` marks the last payload beat. `done` rises in the cycle after the last beat is accepted.
- R6: `crc_err` is high only together with `done`. In check mode it is 1 exactly when the low w bits of `chk_crc`, sampled with the last beat, differ from the computed CRC. Bits of `chk_crc` above w are ignored. In insert mode it stays 0.
- R7: `done` is high in the same cycle as the final output beat of a block: the last CRC beat in insert mode, or the last payload beat in check mode.
- R8: `blk_start` may arrive together with the first beat, and in the cycle in which `done` is high. No idle cycle is needed between blocks, even when the mode or the polynomial changes.
- R9: `in_ready` is low while CRC beats are being appended. It is also low in idle until `blk_start` arrives. Beats offered then produce no output.
- R10: After synchronous reset, `out_valid`, `done`, `crc_err` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Start-of-block strobe, latches selection and clears the remainder |
| poly_sel | input | 3 | Polynomial code (R1) |
| chk_mode | input | 1 | 0 = insert CRC, 1 = check CRC |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DW | Input beat, MSB first |
| in_last | input | 1 | Final payload beat |
| in_nbits | input | NBW | Valid bits on the final beat, MSB-aligned (1..DW) |
| chk_crc | input | CW | Received CRC, right-aligned, sampled with the final beat |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DW | Output beat |
| out_nbits | output | NBW | Valid bits in the output beat |
| out_last | output | 1 | Final output beat of the block |
| done | output | 1 | Block finished |
| crc_err | output | 1 | Check mismatch, valid with done |

## Verification
The hardest situation to reach is a block boundary with no gap. Here a new start strobe and the first beat of the next block arrive in the very cycle that `done` is reported. They may also switch direction and polynomial, while the appended CRC beats of the previous block have only just drained. The bench reaches it by chaining every scenario task straight into the next, with no idle cycle between them. A second hard case is a partial final byte whose unused low bits carry junk. A remainder that agrees in these tests shows that only the counted bits were consumed.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_APP  = 2'd2
  } eng_state_e;

  typedef enum logic [2:0] {
    K_C24A = 3'd0,
    K_C24B = 3'd1,
    K_C16A = 3'd2,
    K_C16B = 3'd3,
    K_C32  = 3'd4,
    K_C18  = 3'd5,
    K_C12  = 3'd6,
    K_C6   = 3'd7
  } crc_kind_e;

endpackage

// File: rtl/crc_poly_rom.sv
module crc_poly_rom
  import crc_engine_pkg::*;
#(
  parameter int CW = 32,
  parameter int WW = $clog2(CW + 1)
) (
  input  logic [2:0]    kind,
  output logic [CW-1:0] poly_left,
  output logic [WW-1:0] width
);

  logic [31:0] poly_r;
  logic [5:0]  w_r;

  always_comb begin
    case (crc_kind_e'(kind))
      K_C24A:  begin poly_r = 32'h0080_0063; w_r = 6'd24; end
      K_C24B:  begin poly_r = 32'h0086_4CFB; w_r = 6'd24; end
      K_C16A:  begin poly_r = 32'h0000_1021; w_r = 6'd16; end
      K_C16B:  begin poly_r = 32'h0000_8005; w_r = 6'd16; end
      K_C32:   begin poly_r = 32'h04C1_1DB7; w_r = 6'd32; end
      K_C18:   begin poly_r = 32'h0002_6DCD; w_r = 6'd18; end
      K_C12:   begin poly_r = 32'h0000_0D31; w_r = 6'd12; end
      default: begin poly_r = 32'h0000_002F; w_r = 6'd6;  end
    endcase
  end

  assign width     = WW'(w_r);
  assign poly_left = CW'(poly_r) << (CW - int'(w_r));

endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int CW  = 32,
  parameter int DW  = 8,
  parameter int NBW = $clog2(DW + 1)
) (
  input  logic [CW-1:0]  crc_in,
  input  logic [DW-1:0]  data,
  input  logic [NBW-1:0] nbits,
  input  logic [CW-1:0]  poly,
  output logic [CW-1:0]  crc_out
);

  // Left-aligned remainder: the feedback tap is always the top bit,
  // whatever the selected width; unused low bits stay zero.
  always_comb begin
    crc_out = crc_in;
    for (int b = 0; b < DW; b++) begin
      if (NBW'(b) < nbits) begin
        crc_out = {crc_out[CW-2:0], 1'b0} ^
                  ((crc_out[CW-1] ^ data[DW-1-b]) ? poly : '0);
      end
    end
  end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 32,
  localparam int NBW  = $clog2(DW + 1),
  localparam int WW   = $clog2(CW + 1),
  localparam int CNTW = $clog2(CW / DW + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           blk_start,
  input  logic [2:0]     poly_sel,
  input  logic           chk_mode,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           in_last,
  input  logic [NBW-1:0] in_nbits,
  input  logic [CW-1:0]  chk_crc,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic [NBW-1:0] out_nbits,
  output logic           out_last,
  output logic           done,
  output logic           crc_err
);

  eng_state_e      st_q;
  logic [2:0]      sel_q;
  logic            mode_q;
  logic [CW-1:0]   crc_q;
  logic [CNTW-1:0] cnt_q;

  logic            start_ok, accept, cur_mode;
  logic [2:0]      cur_sel;
  logic [CW-1:0]   base, poly_left, crc_next;
  logic [WW-1:0]   width;
  logic [NBW-1:0]  nbits_eff, last_bits;
  logic [CNTW-1:0] n_units;
  logic            err_next;

  assign start_ok  = blk_start && (st_q != ST_APP);
  assign in_ready  = (st_q == ST_RUN) || start_ok;
  assign accept    = in_valid && in_ready;
  assign cur_sel   = start_ok ? poly_sel : sel_q;
  assign cur_mode  = start_ok ? chk_mode : mode_q;
  assign base      = start_ok ? '0 : crc_q;
  assign nbits_eff = in_last ? in_nbits : NBW'(DW);

  crc_poly_rom #(.CW(CW), .WW(WW)) u_rom (
    .kind      (cur_sel),
    .poly_left (poly_left),
    .width     (width)
  );

  crc_bit_step #(.CW(CW), .DW(DW), .NBW(NBW)) u_step (
    .crc_in  (base),
    .data    (in_data),
    .nbits   (nbits_eff),
    .poly    (poly_left),
    .crc_out (crc_next)
  );

  always_comb begin
    int nb_i;
    int lb_i;
    nb_i      = (int'(width) + DW - 1) / DW;
    lb_i      = int'(width) - DW * (nb_i - 1);
    n_units   = CNTW'(nb_i);
    last_bits = NBW'(lb_i);
    err_next  = crc_next != (chk_crc << (CW - int'(width)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      sel_q     <= '0;
      mode_q    <= 1'b0;
      crc_q     <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_nbits <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      crc_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      crc_err   <= 1'b0;
      if (accept) begin
        crc_q     <= crc_next;
        sel_q     <= cur_sel;
        mode_q    <= cur_mode;
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_nbits <= nbits_eff;
        cnt_q     <= '0;
        if (!in_last) begin
          st_q <= ST_RUN;
        end else if (cur_mode) begin
          st_q     <= ST_IDLE;
          out_last <= 1'b1;
          done     <= 1'b1;
          crc_err  <= err_next;
        end else begin
          st_q <= ST_APP;
        end
      end else if (st_q == ST_APP) begin
        out_valid <= 1'b1;
        out_data  <= crc_q[CW-1 -: DW];
        crc_q     <= crc_q << DW;
        cnt_q     <= cnt_q + 1'b1;
        if (cnt_q == n_units - 1'b1) begin
          out_nbits <= last_bits;
          out_last  <= 1'b1;
          done      <= 1'b1;
          st_q      <= ST_IDLE;
        end else begin
          out_nbits <= NBW'(DW);
        end
      end else if (start_ok) begin
        st_q   <= ST_RUN;
        sel_q  <= poly_sel;
        mode_q <= chk_mode;
        crc_q  <= '0;
      end
    end
  end

  // R7
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_last));

  // R6
  err_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> done);

  // R3
  last_ends_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> done);

  // R9
  append_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last && !cur_mode) |=> (out_valid && !done && !in_ready));

  // R5
  check_done_next_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last && cur_mode) |=> done);

  // R4
  nbits_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_nbits != '0 && out_nbits <= NBW'(DW)));

endmodule

// File: tb/crc_engine_test.sv
module crc_engine_test;

  localparam int PERIOD = 10;

  logic        clk, rst;
  logic        blk_start, chk_mode, in_valid, in_ready, in_last;
  logic [2:0]  poly_sel;
  logic [7:0]  in_data, out_data;
  logic [3:0]  in_nbits, out_nbits;
  logic [31:0] chk_crc;
  logic        out_valid, out_last, done, crc_err;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [7:0] msg [0:15];

  crc_engine uut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .poly_sel(poly_sel),
    .chk_mode(chk_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_nbits(in_nbits),
    .chk_crc(chk_crc), .out_valid(out_valid), .out_data(out_data),
    .out_nbits(out_nbits), .out_last(out_last), .done(done),
    .crc_err(crc_err)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int ref_w(input int sel);
    case (sel)
      0, 1:    return 24;
      2, 3:    return 16;
      4:       return 32;
      5:       return 18;
      6:       return 12;
      default: return 6;
    endcase
  endfunction

  function automatic logic [31:0] ref_crc(input int sel, input int n,
                                          input int lastbits);
    logic [31:0] p, c, mask;
    int w, nbit;
    logic fb;
    case (sel)
      0:       p = 32'h0080_0063;
      1:       p = 32'h0086_4CFB;
      2:       p = 32'h0000_1021;
      3:       p = 32'h0000_8005;
      4:       p = 32'h04C1_1DB7;
      5:       p = 32'h0002_6DCD;
      6:       p = 32'h0000_0D31;
      default: p = 32'h0000_002F;
    endcase
    w    = ref_w(sel);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    c    = '0;
    for (int i = 0; i < n; i++) begin
      nbit = (i == n - 1) ? lastbits : 8;
      for (int b = 0; b < nbit; b++) begin
        fb = c[w-1] ^ msg[i][7-b];
        c  = (c << 1) & mask;
        if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  task automatic drive_idle();
    blk_start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    in_data = 8'h00; in_nbits = 4'd8; chk_crc = '0;
    poly_sel = 3'd0; chk_mode = 1'b0;
  endtask

  // Runs one block from the current cycle; no idle cycle before it.
  task automatic run_block(input int sel, input bit mode, input int n,
                           input int lastbits, input logic [31:0] rx,
                           input string req);
    logic [31:0] crc, left, mask, expd;
    logic [7:0]  eb;
    logic [3:0]  enb;
    int w, nb, tot, got, it, done_it;
    bit el, err_got, want_err, rdy_run_ok, rdy_app_ok;
    crc  = ref_crc(sel, n, lastbits);
    w    = ref_w(sel);
    nb   = (w + 7) / 8;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    left = crc << (32 - w);
    tot  = n + (mode ? 0 : nb);
    want_err = mode && ((rx & mask) != crc);
    got = 0; it = 0; done_it = -1; err_got = 0;
    rdy_run_ok = 1; rdy_app_ok = 1;
    while (done_it < 0 && it < 60) begin
      if (it < n) begin
        blk_start = (it == 0); in_valid = 1'b1; in_data = msg[it];
        in_last = (it == n - 1);
        in_nbits = (it == n - 1) ? 4'(lastbits) : 4'd8;
        poly_sel = 3'(sel); chk_mode = mode; chk_crc = rx;
        #1;
        if (!in_ready) rdy_run_ok = 0;
      end else begin
        blk_start = 1'b0; in_valid = 1'b1; in_data = 8'hA5;
        in_last = 1'b1; in_nbits = 4'd8;
        #1;
        if (in_ready) rdy_app_ok = 0;
      end
      @(posedge clk);
      @(negedge clk);
      #1;
      if (out_valid) begin
        if (got < n) begin
          eb = msg[got];
          enb = (got == n - 1) ? 4'(lastbits) : 4'd8;
        end else begin
          eb = 8'((left >> (24 - 8 * (got - n))) & 32'hFF);
          enb = (got - n == nb - 1) ? 4'(w - 8 * (nb - 1)) : 4'd8;
        end
        el = (got == tot - 1);
        expd = {19'd0, eb, enb, el};
        chk({19'd0, out_data, out_nbits, out_last} == expd,
            $sformatf("%s beat %0d", req, got),
            {19'd0, out_data, out_nbits, out_last}, expd);
        got++;
      end
      if (done) begin
        done_it = it;
        err_got = crc_err;
      end
      it++;
    end
    in_valid = 1'b0; blk_start = 1'b0;
    // R3 / R5: beat count
    chk(got == tot, {req, " beat count"}, got, tot);
    // R7 / R5: done timing in loop iterations after first beat
    chk(done_it == (mode ? n - 1 : n - 1 + nb), {req, " R7 done cycle"},
        done_it, mode ? n - 1 : n - 1 + nb);
    // R6
    chk(err_got == want_err, {req, " R6 crc_err"}, err_got, want_err);
    // R8: ready in every payload cycle, first one with blk_start
    chk(rdy_run_ok, {req, " R8 in_ready payload"}, rdy_run_ok, 1);
    // R9: not ready while appending
    chk(rdy_app_ok, {req, " R9 in_ready append"}, rdy_app_ok, 0);
  endtask

  task automatic t_reset();
    drive_idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk({out_valid, done, crc_err, in_ready} == 4'b0000, "R10 reset state",
        {out_valid, done, crc_err, in_ready}, 0);
  endtask

  task automatic t_idle_ignore();
    bit seen;
    seen = 0;
    drive_idle();
    in_valid = 1'b1; in_data = 8'h3C; in_last = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (in_ready) seen = 1;
      @(posedge clk);
      @(negedge clk);
      #1;
      if (out_valid || done) seen = 1;
    end
    in_valid = 1'b0;
    chk(!seen, "R9 idle beats without start ignored", seen, 0);
  endtask

  task automatic t_known_value();
    string s;
    s = "123456789";
    for (int i = 0; i < 9; i++) msg[i] = s[i];
    chk(ref_crc(2, 9, 8) == 32'h31C3, "R2 model known value",
        ref_crc(2, 9, 8), 32'h31C3);
    run_block(2, 1'b0, 9, 8, '0, "R2 insert 123456789");
  endtask

  task automatic t_all_polys();
    for (int i = 0; i < 6; i++) msg[i] = 8'(8'h1D * (i + 3) ^ 8'hC6);
    for (int s = 0; s < 8; s++)
      run_block(s, 1'b0, 6, 8, '0, $sformatf("R1 R3 insert sel%0d", s));
  endtask

  task automatic t_partial();
    logic [31:0] a, b2;
    msg[0] = 8'h9E; msg[1] = 8'h42; msg[2] = 8'hB7;
    a = ref_crc(5, 3, 3);
    msg[2] = 8'hA0;
    b2 = ref_crc(5, 3, 3);
    chk(a == b2, "R4 model ignores low bits", a, b2);
    msg[2] = 8'hB7;
    run_block(5, 1'b0, 3, 3, '0, "R4 partial last insert");
    run_block(6, 1'b1, 3, 1, ref_crc(6, 3, 1), "R4 partial last check");
  endtask

  task automatic t_check();
    logic [31:0] c;
    for (int i = 0; i < 7; i++) msg[i] = 8'(8'h37 + 8'd29 * i);
    c = ref_crc(4, 7, 8);
    run_block(4, 1'b1, 7, 8, c, "R5 R6 check good crc32");
    run_block(4, 1'b1, 7, 8, c ^ 32'h0001_0000, "R6 check bad crc32");
    c = ref_crc(7, 7, 8);
    run_block(7, 1'b1, 7, 8, c | 32'hFFFF_FFC0, "R6 check crc6 high junk");
    run_block(7, 1'b1, 7, 8, c ^ 32'h20, "R6 check bad crc6");
    run_block(1, 1'b0, 7, 8, '0, "R8 insert right after check");
    run_block(0, 1'b1, 1, 5, ref_crc(0, 1, 5), "R8 one-beat check");
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_known_value();
    t_all_polys();
    t_partial();
    t_check();
    drive_idle();
    repeat (2) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule